// File: doc/BRIEF.md
# Instruction-Side Page Tag Tracker

This block is a presence-only tag array for the instruction-side address translation cache. It covers 4 KB pages only. It is 4-way set associative with 128 sets. Each entry keeps a page tag, an address-space identifier, a global flag and a valid flag, and nothing else. No physical address is held. A lookup presents a linear address, an address-space identifier and a page-size flag. One cycle later a registered response says whether the page hit. On a miss, the response also gives the way that took the new entry and whether a live entry was displaced.

A second set of inputs maintains the array. One request drops a single page. The other wipes the array, either completely or sparing entries marked global. Maintenance requested in the same cycle as a lookup takes effect before that lookup. Allocation always fills the lowest-numbered empty way of the set. Only a full set falls back to replacing its least recently used way. The top way of a set is therefore written only after ways 0 to 2 are occupied.

Top module: `tlbtrk_top`

## Requirements
- R1: After reset every entry is invalid and no response is flagged. In each set the age order starts with way 0 as least recent and way 3 as most recent.
- R2: The set index is linear address bits [18:12] and the tag is bits [47:19]. A lookup hits when an entry of the indexed set is valid, holds the same tag, and either holds the same address-space identifier or is global. On a hit, rsp_way gives the way that hit.
- R3: A 4 KB lookup that misses writes the entry into the lowest-numbered way whose valid flag is clear. The response shows rsp_fill=1, rsp_evict=0 and rsp_way equal to that way.
- R4: A miss in a set with all four ways valid replaces the least recently used way, with rsp_fill=1 and rsp_evict=1. Every hit and every fill makes the touched way the most recently used.
- R5: An entry written with lk_global=1 hits for any address-space identifier.
- R6: A single-page invalidate (inv_req with inv_addr) clears every valid entry of the addressed set whose tag equals the address tag, whatever its identifier or global flag.
- R7: A flush (fl_req) with fl_keep_global=1 clears every entry except global ones. With fl_keep_global=0 it clears every entry.
- R8: A lookup with lk_page4k=0 still produces rsp_valid=1, but with rsp_hit=0, rsp_fill=0, rsp_evict=0 and rsp_way=0. It changes neither the entries nor the age order.
- R9: The response appears on the clock edge after the request. An invalidate or flush in the same cycle as a lookup is applied before the lookup.
- R10: An invalidated way keeps its place in the age order. A vacant way is nevertheless chosen before the least recently used way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 48 | Lookup linear address |
| lk_asid | input | 12 | Lookup address-space identifier |
| lk_page4k | input | 1 | Request is for a 4 KB page |
| lk_global | input | 1 | Global flag written on allocation |
| inv_req | input | 1 | Single-page invalidate request |
| inv_addr | input | 48 | Linear address to invalidate |
| fl_req | input | 1 | Flush request |
| fl_keep_global | input | 1 | Flush spares global entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fill | output | 1 | Entry allocated |
| rsp_evict | output | 1 | Allocation displaced a valid entry |
| rsp_way | output | 2 | Way that hit or was filled |

## Verification
The hardest state to reach from the ports is a full set whose age order has been reshuffled by hits. A miss in that set must pick a way other than the one that was filled first. That case gets harder still when an invalidate has opened a hole away from the least recent way. The directed sequence fills a single set in order and then hits ways out of order. It misses again, drops one page, and checks that the vacancy beats the least recent way. A random phase then confines traffic to two sets and six tags, so sets fill, evict and get invalidated constantly. Each cycle is compared against a behavioural model that keeps each set's age order as a queue.

// File: rtl/tlbtrk_pkg.sv
package tlbtrk_pkg;
  // default geometry of the tracker
  localparam int unsigned DEF_VA_W       = 48;
  localparam int unsigned DEF_ASID_W     = 12;
  localparam int unsigned DEF_WAYS       = 4;
  localparam int unsigned DEF_SETS       = 128;
  localparam int unsigned DEF_PAGE_SHIFT = 12;

  // kind of action taken for one lookup
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_HIT  = 2'd1,
    ACT_FILL = 2'd2
  } lk_act_e;
endpackage

// File: rtl/tlbtrk_tagram.sv
// One way of tag and identifier storage; write port plus two async read ports.
module tlbtrk_tagram #(
  parameter int unsigned SETS   = 128,
  parameter int unsigned TAG_W  = 29,
  parameter int unsigned ASID_W = 12,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [TAG_W-1:0]  wtag,
  input  logic [ASID_W-1:0] wasid,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [ASID_W-1:0] ra_asid,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [TAG_W-1:0]  rb_tag
);
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [ASID_W-1:0] asid_mem [SETS];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[widx]  <= wtag;
      asid_mem[widx] <= wasid;
    end
  end

  assign ra_tag  = tag_mem[ra_idx];
  assign ra_asid = asid_mem[ra_idx];
  assign rb_tag  = tag_mem[rb_idx];
endmodule

// File: rtl/tlbtrk_valid.sv
// Valid and global flags held in flops so a flush completes in one cycle.
module tlbtrk_valid #(
  parameter int unsigned WAYS = 4,
  parameter int unsigned SETS = 128,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_en,
  input  logic             flush_keep_g,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [WAYS-1:0]  inv_mask,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAYS-1:0]  rd_valid,
  output logic [WAYS-1:0]  rd_glob,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             fill_glob
);
  logic [WAYS-1:0] vld_q  [SETS];
  logic [WAYS-1:0] glob_q [SETS];
  logic [WAYS-1:0] vld_d  [SETS];

  // maintenance seen by the lookup in the same cycle
  always_comb begin
    rd_glob  = glob_q[rd_idx];
    rd_valid = vld_q[rd_idx];
    if (flush_en)
      rd_valid = rd_valid & (flush_keep_g ? rd_glob : '0);
    if (inv_en && inv_idx == rd_idx)
      rd_valid = rd_valid & ~inv_mask;
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      vld_d[s] = vld_q[s];
      if (flush_en)
        vld_d[s] = vld_d[s] & (flush_keep_g ? glob_q[s] : '0);
      if (inv_en && inv_idx == IDX_W'(s))
        vld_d[s] = vld_d[s] & ~inv_mask;
      if (fill_en && rd_idx == IDX_W'(s))
        vld_d[s][fill_way] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        glob_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= vld_d[s];
      if (fill_en) glob_q[rd_idx][fill_way] <= fill_glob;
    end
  end

  // a filled way reads back as valid on the next cycle unless maintenance hit it
  assert_fill_sticks_R3: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush_en && !inv_en) |=> vld_q[$past(rd_idx)][$past(fill_way)]);
endmodule

// File: rtl/tlbtrk_lru.sv
// Per-set age order: age 0 = most recent, WAYS-1 = least recent.
module tlbtrk_lru #(
  parameter int unsigned WAYS = 4,
  parameter int unsigned SETS = 128,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic [WAY_W-1:0] oldest,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way
);
  typedef logic [WAYS-1:0][WAY_W-1:0] ages_t;

  ages_t age_q [SETS];
  ages_t cur;
  ages_t nxt;
  logic [WAYS-1:0] rank_seen;

  assign cur = age_q[idx];

  always_comb begin
    oldest = '0;
    for (int w = 0; w < WAYS; w++)
      if (cur[w] == WAY_W'(WAYS-1)) oldest = WAY_W'(w);
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_age
      always_comb begin
        if (WAY_W'(w) == touch_way)             nxt[w] = '0;
        else if (cur[w] < cur[touch_way])       nxt[w] = cur[w] + 1'b1;
        else                                    nxt[w] = cur[w];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(WAYS-1-w);
    end else if (touch_en) begin
      age_q[idx] <= nxt;
    end
  end

  always_comb begin
    rank_seen = '0;
    for (int w = 0; w < WAYS; w++) rank_seen[cur[w]] = 1'b1;
  end

  // ages of a set always stay a permutation
  assert_age_perm_R4: assert property (@(posedge clk) disable iff (rst)
    rank_seen == '1);
  // a touched way is most recent next cycle
  assert_touch_mru_R4: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> age_q[$past(idx)][$past(touch_way)] == '0);
endmodule

// File: rtl/tlbtrk_top.sv
module tlbtrk_top
  import tlbtrk_pkg::*;
#(
  parameter int unsigned VA_W       = DEF_VA_W,
  parameter int unsigned ASID_W     = DEF_ASID_W,
  parameter int unsigned WAYS       = DEF_WAYS,
  parameter int unsigned SETS       = DEF_SETS,
  parameter int unsigned PAGE_SHIFT = DEF_PAGE_SHIFT,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned TAG_LO = PAGE_SHIFT + IDX_W,
  localparam int unsigned TAG_W  = VA_W - TAG_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_addr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_page4k,
  input  logic              lk_global,
  input  logic              inv_req,
  input  logic [VA_W-1:0]   inv_addr,
  input  logic              fl_req,
  input  logic              fl_keep_global,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fill,
  output logic              rsp_evict,
  output logic [WAY_W-1:0]  rsp_way
);
  logic [IDX_W-1:0] lk_idx, inv_idx;
  logic [TAG_W-1:0] lk_tag, inv_tag;
  logic [WAYS-1:0]  vld_eff, glob_rd, match, inv_mask;
  logic [WAY_W-1:0] hit_way, vac_way, lru_way, fill_way, pick_way;
  logic             hit, any_vac, lk_go, do_fill;
  lk_act_e          act;

  assign lk_idx  = lk_addr[PAGE_SHIFT +: IDX_W];
  assign lk_tag  = lk_addr[TAG_LO +: TAG_W];
  assign inv_idx = inv_addr[PAGE_SHIFT +: IDX_W];
  assign inv_tag = inv_addr[TAG_LO +: TAG_W];
  assign lk_go   = lk_valid && lk_page4k;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0]  ra_tag, rb_tag;
      logic [ASID_W-1:0] ra_asid;

      tlbtrk_tagram #(.SETS(SETS), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_ram (
        .clk    (clk),
        .we     (do_fill && fill_way == WAY_W'(w)),
        .widx   (lk_idx),
        .wtag   (lk_tag),
        .wasid  (lk_asid),
        .ra_idx (lk_idx),
        .ra_tag (ra_tag),
        .ra_asid(ra_asid),
        .rb_idx (inv_idx),
        .rb_tag (rb_tag)
      );

      assign match[w]    = vld_eff[w] && ra_tag == lk_tag &&
                           (ra_asid == lk_asid || glob_rd[w]);
      assign inv_mask[w] = rb_tag == inv_tag;
    end
  endgenerate

  tlbtrk_valid #(.WAYS(WAYS), .SETS(SETS)) u_valid (
    .clk         (clk),
    .rst         (rst),
    .flush_en    (fl_req),
    .flush_keep_g(fl_keep_global),
    .inv_en      (inv_req),
    .inv_idx     (inv_idx),
    .inv_mask    (inv_mask),
    .rd_idx      (lk_idx),
    .rd_valid    (vld_eff),
    .rd_glob     (glob_rd),
    .fill_en     (do_fill),
    .fill_way    (fill_way),
    .fill_glob   (lk_global)
  );

  tlbtrk_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .idx      (lk_idx),
    .oldest   (lru_way),
    .touch_en (lk_go),
    .touch_way(pick_way)
  );

  // lowest-numbered hit and lowest-numbered vacancy
  always_comb begin
    hit_way = '0;
    vac_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (match[w])    hit_way = WAY_W'(w);
      if (!vld_eff[w]) vac_way = WAY_W'(w);
    end
  end

  assign hit      = |match;
  assign any_vac  = ~&vld_eff;
  assign fill_way = any_vac ? vac_way : lru_way;
  assign do_fill  = lk_go && !hit;
  assign pick_way = hit ? hit_way : fill_way;

  always_comb begin
    if (!lk_go)   act = ACT_NONE;
    else if (hit) act = ACT_HIT;
    else          act = ACT_FILL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fill  <= 1'b0;
      rsp_evict <= 1'b0;
      rsp_way   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= act == ACT_HIT;
      rsp_fill  <= act == ACT_FILL;
      rsp_evict <= act == ACT_FILL && !any_vac;
      rsp_way   <= act == ACT_NONE ? '0 : pick_way;
    end
  end

  assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_fill);
  assert_hit_xor_fill_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_fill}));
  assert_evict_needs_fill_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_evict |-> rsp_fill);
  assert_other_size_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_page4k) |=> !rsp_hit && !rsp_fill && !rsp_evict);
  assert_full_flush_first_R7: assert property (@(posedge clk) disable iff (rst)
    (lk_go && fl_req && !fl_keep_global) |=> !rsp_hit && !rsp_evict);
endmodule

// File: tb/sim_tlbtrk_top.sv
`timescale 1ns/1ps
module sim_tlbtrk_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_page4k, lk_global, inv_req, fl_req, fl_keep_global;
  logic [47:0] lk_addr, inv_addr;
  logic [11:0] lk_asid;
  logic        rsp_valid, rsp_hit, rsp_fill, rsp_evict;
  logic [1:0]  rsp_way;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  tlbtrk_top u0 (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_asid(lk_asid),
    .lk_page4k(lk_page4k), .lk_global(lk_global),
    .inv_req(inv_req), .inv_addr(inv_addr),
    .fl_req(fl_req), .fl_keep_global(fl_keep_global),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fill(rsp_fill),
    .rsp_evict(rsp_evict), .rsp_way(rsp_way)
  );

  // behavioural reference: flags per entry, age order as a queue (front = oldest)
  bit          m_v   [128][4];
  bit          m_g   [128][4];
  logic [28:0] m_tag [128][4];
  logic [11:0] m_as  [128][4];
  int          ord   [128][$];

  bit       e_valid, e_hit, e_fill, e_evict;
  int       e_way;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual cycles=%0d expected<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [47:0] mk(input logic [28:0] tag, input int set);
    return {tag, 7'(set), 12'h0};
  endfunction

  function automatic void m_reset();
    for (int s = 0; s < 128; s++) begin
      ord[s].delete();
      for (int w = 0; w < 4; w++) begin
        m_v[s][w] = 0; m_g[s][w] = 0;
        ord[s].push_back(w);
      end
    end
  endfunction

  function automatic void m_touch(input int s, input int w);
    for (int i = 0; i < ord[s].size(); i++)
      if (ord[s][i] == w) begin ord[s].delete(i); break; end
    ord[s].push_back(w);
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model, compare at next negedge
  task automatic step(input bit lv, input logic [47:0] la, input logic [11:0] las,
                      input bit l4k, input bit lg, input bit iv, input logic [47:0] ia,
                      input bit fl, input bit fk, input string rq);
    int s, hw, vw;
    lk_valid = lv; lk_addr = la; lk_asid = las; lk_page4k = l4k; lk_global = lg;
    inv_req = iv; inv_addr = ia; fl_req = fl; fl_keep_global = fk;
    if (fl)
      for (int a = 0; a < 128; a++)
        for (int w = 0; w < 4; w++)
          if (!(fk && m_g[a][w])) m_v[a][w] = 0;
    if (iv) begin
      s = int'(ia[18:12]);
      for (int w = 0; w < 4; w++)
        if (m_v[s][w] && m_tag[s][w] == ia[47:19]) m_v[s][w] = 0;
    end
    e_valid = lv; e_hit = 0; e_fill = 0; e_evict = 0; e_way = 0;
    if (lv && l4k) begin
      s = int'(la[18:12]);
      hw = -1;
      for (int w = 3; w >= 0; w--)
        if (m_v[s][w] && m_tag[s][w] == la[47:19] && (m_as[s][w] == las || m_g[s][w])) hw = w;
      if (hw >= 0) begin
        e_hit = 1; e_way = hw;
      end else begin
        vw = -1;
        for (int w = 3; w >= 0; w--) if (!m_v[s][w]) vw = w;
        e_fill = 1;
        if (vw < 0) begin vw = ord[s][0]; e_evict = 1; end
        e_way = vw;
        m_v[s][vw] = 1; m_g[s][vw] = lg; m_tag[s][vw] = la[47:19]; m_as[s][vw] = las;
      end
      m_touch(s, e_way);
    end
    @(negedge clk);
    check(rq, "rsp_valid", int'(rsp_valid), int'(e_valid));
    if (e_valid) begin
      check(rq, "rsp_hit",   int'(rsp_hit),   int'(e_hit));
      check(rq, "rsp_fill",  int'(rsp_fill),  int'(e_fill));
      check(rq, "rsp_evict", int'(rsp_evict), int'(e_evict));
      check(rq, "rsp_way",   int'(rsp_way),   e_way);
    end
  endtask

  task automatic look(input logic [28:0] t, input int s, input logic [11:0] a, input string rq);
    step(1, mk(t, s), a, 1, 0, 0, '0, 0, 0, rq);
  endtask

  // hand-derived expectation of the last response
  task automatic expect_rsp(input bit h, input bit f, input bit e, input int w, input string rq);
    check(rq, "hand hit",   int'(rsp_hit),   int'(h));
    check(rq, "hand fill",  int'(rsp_fill),  int'(f));
    check(rq, "hand evict", int'(rsp_evict), int'(e));
    check(rq, "hand way",   int'(rsp_way),   w);
  endtask

  initial begin
    rst = 1;
    lk_valid = 0; lk_addr = '0; lk_asid = '0; lk_page4k = 0; lk_global = 0;
    inv_req = 0; inv_addr = '0; fl_req = 0; fl_keep_global = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: idle after reset shows nothing
    step(0, '0, '0, 0, 0, 0, '0, 0, 0, "R1");
    check("R1", "rsp_valid idle", int'(rsp_valid), 0);

    // R3: fill set 5 in way order, no eviction
    for (int i = 0; i < 4; i++) begin
      look(29'(100 + i), 5, 12'd1, "R3");
      expect_rsp(0, 1, 0, i, "R3");
    end
    // R2: hits report the way; reorder ages (oldest now way 2)
    look(29'd101, 5, 12'd1, "R2"); expect_rsp(1, 0, 0, 1, "R2");
    look(29'd100, 5, 12'd1, "R2"); expect_rsp(1, 0, 0, 0, "R2");
    // R4: full set replaces least recent (way 2)
    look(29'd104, 5, 12'd1, "R4"); expect_rsp(0, 1, 1, 2, "R4");
    // R2: same tag, other identifier misses; evicts way 3
    look(29'd101, 5, 12'd2, "R2"); expect_rsp(0, 1, 1, 3, "R2");
    // R6 and R10: drop way 0, then a miss takes the vacancy rather than LRU way 1
    step(0, '0, '0, 0, 0, 1, mk(29'd100, 5), 0, 0, "R6");
    look(29'd103, 5, 12'd1, "R10"); expect_rsp(0, 1, 0, 0, "R10");
    // R5: global entry matches any identifier
    step(1, mk(29'd200, 9), 12'd3, 1, 1, 0, '0, 0, 0, "R5");
    expect_rsp(0, 1, 0, 0, "R5");
    look(29'd200, 9, 12'd7, "R5"); expect_rsp(1, 0, 0, 0, "R5");
    // R7: flush sparing globals
    step(0, '0, '0, 0, 0, 0, '0, 1, 1, "R7");
    look(29'd200, 9, 12'd4, "R7"); expect_rsp(1, 0, 0, 0, "R7");
    look(29'd104, 5, 12'd1, "R7"); expect_rsp(0, 1, 0, 0, "R7");
    // R9: full flush in same cycle as lookup wins
    step(1, mk(29'd200, 9), 12'd3, 1, 0, 0, '0, 1, 0, "R9");
    expect_rsp(0, 1, 0, 0, "R9");
    // R8: other page size neither hits nor fills nor changes state
    step(1, mk(29'd200, 9), 12'd3, 0, 0, 0, '0, 0, 0, "R8");
    expect_rsp(0, 0, 0, 0, "R8");
    step(1, mk(29'd201, 9), 12'd3, 0, 0, 0, '0, 0, 0, "R8");
    look(29'd201, 9, 12'd3, "R8"); expect_rsp(0, 1, 0, 1, "R8");
    // R9 with R6: invalidate and lookup of same page together -> miss into freed way 1
    step(1, mk(29'd201, 9), 12'd3, 1, 0, 1, mk(29'd201, 9), 0, 0, "R9");
    expect_rsp(0, 1, 0, 1, "R9");
    // R2: bit 12 selects different sets
    look(29'd300, 10, 12'd1, "R2"); expect_rsp(0, 1, 0, 0, "R2");
    look(29'd300, 11, 12'd1, "R2"); expect_rsp(0, 1, 0, 0, "R2");

    // random traffic on two sets and a small tag pool (R2..R10)
    for (int n = 0; n < 3000; n++) begin
      automatic logic [28:0] t  = 29'(500 + $urandom_range(0, 5));
      automatic int          s  = 3 + $urandom_range(0, 1);
      automatic logic [28:0] ti = 29'(500 + $urandom_range(0, 5));
      automatic int          si = 3 + $urandom_range(0, 1);
      step($urandom_range(0, 9) < 8, mk(t, s), 12'($urandom_range(1, 2)),
           $urandom_range(0, 9) != 0, $urandom_range(0, 4) == 0,
           $urandom_range(0, 9) == 0, mk(ti, si),
           $urandom_range(0, 29) == 0, $urandom_range(0, 1) == 1, "R4");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule